// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block sits beside an SDRAM command bus and samples the registered control pins once per clock: chip select, row strobe, column strobe, write enable, clock enable, a 13-bit address (bit 10 is the precharge/auto-precharge qualifier) and a 2-bit bank select. It turns each pin pattern into a command code. For each of four banks it keeps whether a row is open and which row that is. It raises a one-cycle flag when a command breaks the bank-state rules.

The block has a small mode store, loaded by the mode-register command, which holds the burst length and the single-location-write option. It uses these to close a bank by itself at the end of a burst that asked for auto-precharge. It follows self refresh entry and exit. It also derives two data-mask controls: a write mask that acts in the same cycle, and a read output-disable that trails the mask pin by two clocks.

All command-related outputs are registered. A command sampled at clock edge n shows on the outputs just after edge n. The bank states change at that same edge.

Top module: `sdcmd_tracker`

## Requirements
- R1: After the edge that samples the pins, `cmd_o` holds the decoded code. The pin order is {cs_n, ras_n, cas_n, we_n}. cs_n high gives 0 (inhibit). 0111 gives 1 (NOP). 0011 gives 2 (activate). 0101 gives 3 (read). 0100 gives 4 (write). 0110 gives 5 (burst stop). 0010 gives 6 (precharge). 0001 gives 7 (auto refresh) when cke is high and 8 (self refresh entry) when cke is low. 0000 gives 9 (mode load). Every cycle spent in self refresh reports 10.
- R2: A legal activate marks bank `ba` open and stores `addr` as that bank's row. The row stays in place until the bank is closed.
- R3: An activate to a bank that is already open pulses `illegal_o` and leaves every bank state and row unchanged.
- R4: A precharge with addr[10] high closes all banks whatever `ba` is. With addr[10] low it closes only bank `ba`. A precharge is never flagged.
- R5: A read or write with addr[10] high closes its bank at the edge that lies burst-length edges after the command edge. The mode load sets the burst length through addr[2:0]: 000=1, 001=2, 010=4, 011=8, 111=full page, and other codes mean 1. When addr[9]=1 in the mode load, every write is a one-location burst. In full-page mode the request is ignored and the bank stays open.
- R6: A read or write to an idle bank pulses `illegal_o` and has no effect.
- R7: A mode load, auto refresh or self refresh entry while any bank is open pulses `illegal_o`, and the mode and self refresh state stay as they were.
- R8: A legal self refresh entry stops the burst in progress. From the next edge, every input except cke is ignored. The first edge with cke high ends the state, and that edge's command is also ignored.
- R9: `rd_hiz_o` equals the `dqm` value sampled two edges earlier.
- R10: `wr_mask_o` equals `dqm` during the cycle of a legal write command and during the following write beats of that burst (burst length minus one cycles). At all other times it is 0.
- R11: A synchronous active-low reset leaves every bank idle with row 0, `cmd_o`=0, `illegal_o`=0, `rd_hiz_o`=0, a burst length of 1 and no self refresh.
- R12: A pending auto-precharge is dropped by a burst stop, by a newer read or write, or by a precharge that covers its bank, issued at or before the closing edge. A bank dropped this way stays open unless that precharge closed it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable; selects refresh kind and ends self refresh |
| addr | input | 13 | Row address / column address / mode code; bit 10 is the close qualifier |
| ba | input | 2 | Bank select |
| dqm | input | 1 | Data mask pin |
| cmd_o | output | 4 | Registered command code (R1) |
| illegal_o | output | 1 | One-cycle pulse for a rule-breaking command |
| bank_open_o | output | 4 | Per-bank open flag, bit i for bank i |
| bank_row_o | output | 52 | Per-bank row, bank i at bits [13i+12:13i] |
| rd_hiz_o | output | 1 | Read output-disable, mask delayed two clocks |
| wr_mask_o | output | 1 | Write data mask, same cycle |

## Verification
The assertions assume that every pin holds a known 0 or 1 at each sampled edge and that reset is held across at least one edge before it is released. They also assume the outputs that follow a command relate only to the pins sampled at that one edge. The bench therefore changes every input at the falling edge, holds it steady through the rising edge, and drives known values only. The random phase picks among all nine pin patterns, including cs_n high, and lowers cke now and then. This lets self refresh, illegal commands and auto-precharge collisions arise without breaking those assumptions.

// File: rtl/sdcmd_pkg.sv
// Shared command codes and burst-length helper for the SDRAM command tracker.
// Assumes the mode burst-length field is three bits wide.
package sdcmd_pkg;

    typedef enum logic [3:0] {
        CMD_INHIBIT = 4'd0,
        CMD_NOP     = 4'd1,
        CMD_ACTIVE  = 4'd2,
        CMD_READ    = 4'd3,
        CMD_WRITE   = 4'd4,
        CMD_BTERM   = 4'd5,
        CMD_PRECH   = 4'd6,
        CMD_AREF    = 4'd7,
        CMD_SREF    = 4'd8,
        CMD_LMR     = 4'd9,
        CMD_SLEEP   = 4'd10
    } cmd_e;

    localparam logic [2:0] BL_PAGE_CODE = 3'b111;

    // Beat count of a fixed burst-length code; unknown codes fall back to 1.
    function automatic int unsigned beats_for(input logic [2:0] code);
        case (code)
            3'b001:  return 2;
            3'b010:  return 4;
            3'b011:  return 8;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/sdcmd_decode.sv
// Pure pin-pattern decoder: maps the four strobes plus cke to a command code.
// Assumes the pins are already registered; no state is held here.
module sdcmd_decode
    import sdcmd_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic cke,
    output cmd_e cmd
);

    // Truth-table decode of the strobe pattern.
    always_comb begin
        if (cs_n) begin
            cmd = CMD_INHIBIT;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b111:  cmd = CMD_NOP;
                3'b011:  cmd = CMD_ACTIVE;
                3'b101:  cmd = CMD_READ;
                3'b100:  cmd = CMD_WRITE;
                3'b110:  cmd = CMD_BTERM;
                3'b010:  cmd = CMD_PRECH;
                3'b001:  cmd = cke ? CMD_AREF : CMD_SREF;
                default: cmd = CMD_LMR;
            endcase
        end
    end

endmodule

// File: rtl/sdcmd_bank.sv
// State of one bank: open flag and stored row.
// Assumes the caller never asks to open and close in the same cycle.
module sdcmd_bank #(
    parameter int ROW_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_i,
    input  logic [ROW_W-1:0] row_i,
    input  logic             close_i,
    output logic             is_open_o,
    output logic [ROW_W-1:0] row_o
);

    // Open on a granted activate, close on any precharge source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_open_o <= 1'b0;
            row_o     <= '0;
        end else if (open_i) begin
            is_open_o <= 1'b1;
            row_o     <= row_i;
        end else if (close_i) begin
            is_open_o <= 1'b0;
        end
    end

    AST_OPEN_CLOSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(open_i && close_i)); // R4

    AST_CLOSED_ROW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_open_o && !open_i) |=> $stable(row_o)); // R2

endmodule

// File: rtl/sdcmd_burst.sv
// Tracks the single burst in flight: remaining beats, its bank, whether it
// writes and whether it will auto-close the bank when it ends.
// Assumes at most one burst is active; a new start replaces the old one.
module sdcmd_burst #(
    parameter int PAGE_COLS = 512,
    parameter int BA_W      = 2,
    localparam int CNT_W    = $clog2(PAGE_COLS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic            is_wr_i,
    input  logic [CNT_W-1:0] len_i,
    input  logic            ap_i,
    input  logic [BA_W-1:0] bank_i,
    input  logic            stop_i,
    input  logic            pre_i,
    input  logic            pre_all_i,
    output logic            close_o,
    output logic [BA_W-1:0] close_bank_o,
    output logic            wr_beat_o
);

    logic [CNT_W-1:0] left_q;
    logic             wr_q;
    logic             ap_q;
    logic [BA_W-1:0]  bank_q;
    logic             kill;

    // A precharge covering the burst's bank cancels the pending close.
    assign kill = pre_i && (pre_all_i || (bank_i == bank_q));

    // Load, stop or count down the burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
            wr_q   <= 1'b0;
            ap_q   <= 1'b0;
            bank_q <= '0;
        end else if (start_i) begin
            left_q <= len_i;
            wr_q   <= is_wr_i;
            ap_q   <= ap_i;
            bank_q <= bank_i;
        end else if (stop_i) begin
            left_q <= '0;
            ap_q   <= 1'b0;
        end else begin
            if (left_q != '0) left_q <= left_q - 1'b1;
            if (kill || left_q == CNT_W'(1)) ap_q <= 1'b0;
        end
    end

    // Close fires on the last-beat edge unless something replaces the burst.
    assign close_o      = ap_q && (left_q == CNT_W'(1)) && !start_i && !stop_i;
    assign close_bank_o = bank_q;
    assign wr_beat_o    = wr_q && (left_q >= CNT_W'(2));

    AST_LEFT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        left_q <= CNT_W'(PAGE_COLS)); // R5

    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i) |=> (left_q == '0 && !ap_q)); // R12

endmodule

// File: rtl/sdcmd_tracker.sv
// Top of the SDRAM command tracker: decodes commands, judges legality
// against bank state, keeps the mode store, self refresh state and the
// data-mask controls. Assumes inputs are registered pins sampled each edge.
module sdcmd_tracker
    import sdcmd_pkg::*;
#(
    parameter int NUM_BANKS  = 4,
    parameter int ROW_W      = 13,
    parameter int AP_BIT     = 10,
    parameter int WS_BIT     = 9,
    parameter int PAGE_COLS  = 512,
    parameter int RD_DQM_LAT = 2,
    localparam int BA_W      = $clog2(NUM_BANKS),
    localparam int CNT_W     = $clog2(PAGE_COLS + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cs_n,
    input  logic                       ras_n,
    input  logic                       cas_n,
    input  logic                       we_n,
    input  logic                       cke,
    input  logic [ROW_W-1:0]           addr,
    input  logic [BA_W-1:0]            ba,
    input  logic                       dqm,
    output logic [3:0]                 cmd_o,
    output logic                       illegal_o,
    output logic [NUM_BANKS-1:0]       bank_open_o,
    output logic [NUM_BANKS*ROW_W-1:0] bank_row_o,
    output logic                       rd_hiz_o,
    output logic                       wr_mask_o
);

    cmd_e             dec;
    cmd_e             cmd_eff;
    logic             in_sr_q;
    logic [2:0]       mode_bl_q;
    logic             mode_ws_q;
    logic [ROW_W-1:0] rows_w [NUM_BANKS];
    logic             tgt_open, any_open, illegal_now;
    logic             rw_go, is_wr, single_wr, page, ap_req;
    logic             pre_go, stop, sref_go, lmr_go;
    logic [CNT_W-1:0] len;
    logic             ap_close, wr_beat;
    logic [BA_W-1:0]  ap_bank;

    sdcmd_decode u_dec (
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .cke(cke), .cmd(dec)
    );

    // Self refresh hides the pins behind a sleep code.
    assign cmd_eff  = in_sr_q ? CMD_SLEEP : dec;
    assign tgt_open = bank_open_o[ba];
    assign any_open = |bank_open_o;

    // Rule check against the bank state before this edge.
    always_comb begin
        case (cmd_eff)
            CMD_ACTIVE:                   illegal_now = tgt_open;
            CMD_READ, CMD_WRITE:          illegal_now = !tgt_open;
            CMD_LMR, CMD_AREF, CMD_SREF:  illegal_now = any_open;
            default:                      illegal_now = 1'b0;
        endcase
    end

    // Burst launch parameters derived from the mode store.
    assign is_wr     = (cmd_eff == CMD_WRITE);
    assign rw_go     = (cmd_eff == CMD_READ || is_wr) && !illegal_now;
    assign single_wr = is_wr && mode_ws_q;
    assign page      = (mode_bl_q == BL_PAGE_CODE) && !single_wr;
    assign len       = single_wr ? CNT_W'(1) :
                       page      ? CNT_W'(PAGE_COLS) : CNT_W'(beats_for(mode_bl_q));
    assign ap_req    = addr[AP_BIT] && !page;
    assign pre_go    = (cmd_eff == CMD_PRECH);
    assign sref_go   = (cmd_eff == CMD_SREF) && !illegal_now;
    assign lmr_go    = (cmd_eff == CMD_LMR) && !illegal_now;
    assign stop      = (cmd_eff == CMD_BTERM) || sref_go;

    sdcmd_burst #(.PAGE_COLS(PAGE_COLS), .BA_W(BA_W)) u_burst (
        .clk(clk), .rst_n(rst_n), .start_i(rw_go), .is_wr_i(is_wr),
        .len_i(len), .ap_i(ap_req), .bank_i(ba), .stop_i(stop),
        .pre_i(pre_go), .pre_all_i(addr[AP_BIT]),
        .close_o(ap_close), .close_bank_o(ap_bank), .wr_beat_o(wr_beat)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic act_en, close_en;
        assign act_en   = (cmd_eff == CMD_ACTIVE) && !illegal_now && (ba == BA_W'(b));
        assign close_en = (pre_go && (addr[AP_BIT] || ba == BA_W'(b))) ||
                          (ap_close && ap_bank == BA_W'(b));
        sdcmd_bank #(.ROW_W(ROW_W)) u_bank (
            .clk(clk), .rst_n(rst_n), .open_i(act_en), .row_i(addr),
            .close_i(close_en), .is_open_o(bank_open_o[b]), .row_o(rows_w[b])
        );
        assign bank_row_o[b*ROW_W +: ROW_W] = rows_w[b];
    end

    // Mode store: burst-length code and single-write option.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_bl_q <= 3'b000;
            mode_ws_q <= 1'b0;
        end else if (lmr_go) begin
            mode_bl_q <= addr[2:0];
            mode_ws_q <= addr[WS_BIT];
        end
    end

    // Self refresh state: enter on a legal entry, leave when cke returns.
    always_ff @(posedge clk) begin
        if (!rst_n)              in_sr_q <= 1'b0;
        else if (in_sr_q && cke) in_sr_q <= 1'b0;
        else if (sref_go)        in_sr_q <= 1'b1;
    end

    // Registered command code and rule-break pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_o     <= CMD_INHIBIT;
            illegal_o <= 1'b0;
        end else begin
            cmd_o     <= cmd_eff;
            illegal_o <= illegal_now;
        end
    end

    // Read mask delay line, one register per clock of latency.
    logic [RD_DQM_LAT-1:0] hiz_pipe;
    for (genvar s = 0; s < RD_DQM_LAT; s++) begin : g_hiz
        always_ff @(posedge clk) begin
            if (!rst_n)      hiz_pipe[s] <= 1'b0;
            else if (s == 0) hiz_pipe[s] <= dqm;
            else             hiz_pipe[s] <= hiz_pipe[(s == 0) ? 0 : s-1];
        end
    end
    assign rd_hiz_o = hiz_pipe[RD_DQM_LAT-1];

    // Write mask acts in the same cycle as the data it covers.
    assign wr_mask_o = dqm && ((rw_go && is_wr) || wr_beat);

    AST_ACT_STORES_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_ACTIVE && !illegal_o) |->
        (bank_open_o[$past(ba)] && rows_w[$past(ba)] == $past(addr))); // R2

    AST_BAD_ACT_KEEPS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_ACTIVE && illegal_o) |-> $stable(bank_row_o)); // R3

    AST_PRE_ALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_PRECH && $past(addr[AP_BIT])) |-> (bank_open_o == '0)); // R4

    AST_RW_ON_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_o == CMD_READ || cmd_o == CMD_WRITE) && !illegal_o) |->
        bank_open_o[$past(ba)]); // R6

    AST_LMR_ALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_LMR && !illegal_o) |-> (bank_open_o == '0)); // R7

    AST_SLEEP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_SLEEP) |-> ($stable(bank_open_o) && !illegal_o)); // R8

    AST_HIZ_FIRST_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        hiz_pipe[0] == $past(dqm)); // R9

endmodule

// File: tb/sim_sdcmd_tracker.sv
module sim_sdcmd_tracker;

    localparam int CLK_PERIOD = 10;

    localparam logic [3:0] P_INH = 4'b1111;
    localparam logic [3:0] P_NOP = 4'b0111;
    localparam logic [3:0] P_ACT = 4'b0011;
    localparam logic [3:0] P_RD  = 4'b0101;
    localparam logic [3:0] P_WR  = 4'b0100;
    localparam logic [3:0] P_BT  = 4'b0110;
    localparam logic [3:0] P_PRE = 4'b0010;
    localparam logic [3:0] P_REF = 4'b0001;
    localparam logic [3:0] P_LMR = 4'b0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic        cke = 1'b1;
    logic [12:0] addr = '0;
    logic [1:0]  ba = '0;
    logic        dqm = 1'b0;
    logic [3:0]  cmd_o;
    logic        illegal_o;
    logic [3:0]  bank_open_o;
    logic [51:0] bank_row_o;
    logic        rd_hiz_o;
    logic        wr_mask_o;

    sdcmd_tracker u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .cke(cke), .addr(addr), .ba(ba), .dqm(dqm),
        .cmd_o(cmd_o), .illegal_o(illegal_o), .bank_open_o(bank_open_o),
        .bank_row_o(bank_row_o), .rd_hiz_o(rd_hiz_o), .wr_mask_o(wr_mask_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_req  = "R11";

    // Reference model state
    bit m_open[4];
    int m_row[4];
    int m_cmd;
    bit m_ill;
    int m_bl;
    bit m_ws;
    bit m_sr;
    int b_left;
    bit b_wr;
    bit b_ap;
    int b_bank;
    bit dq_hist[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int decode(input logic [3:0] p, input logic ck);
        if (p[3]) return 0;
        if (p == P_NOP) return 1;
        if (p == P_ACT) return 2;
        if (p == P_RD)  return 3;
        if (p == P_WR)  return 4;
        if (p == P_BT)  return 5;
        if (p == P_PRE) return 6;
        if (p == P_REF) return ck ? 7 : 8;
        return 9;
    endfunction

    function automatic int blen(input int code);
        if (code == 1) return 2;
        if (code == 2) return 4;
        if (code == 3) return 8;
        if (code == 7) return 512;
        return 1;
    endfunction

    function automatic bit judge(input int eff, input int b);
        bit any = m_open[0] | m_open[1] | m_open[2] | m_open[3];
        if (eff == 2) return m_open[b];
        if (eff == 3 || eff == 4) return !m_open[b];
        if (eff == 7 || eff == 8 || eff == 9) return any;
        return 1'b0;
    endfunction

    task automatic model_reset();
        for (int k = 0; k < 4; k++) begin m_open[k] = 0; m_row[k] = 0; end
        m_cmd = 0; m_ill = 0; m_bl = 0; m_ws = 0; m_sr = 0;
        b_left = 0; b_wr = 0; b_ap = 0; b_bank = 0;
        dq_hist = {1'b0, 1'b0};
    endtask

    task automatic model_update(input logic [3:0] p, input logic ck,
                                input logic [12:0] a, input int b, input logic dq);
        int  eff  = m_sr ? 10 : decode(p, ck);
        bit  ill  = m_sr ? 1'b0 : judge(eff, b);
        bit  rw   = (eff == 3 || eff == 4) && !ill;
        bit  stp  = (eff == 5) || (eff == 8 && !ill);
        bit  fire = b_ap && b_left == 1 && !rw && !stp;
        for (int k = 0; k < 4; k++) begin
            if (eff == 2 && !ill && k == b) begin m_open[k] = 1; m_row[k] = a; end
            else if ((eff == 6 && (a[10] || k == b)) || (fire && k == b_bank)) m_open[k] = 0;
        end
        if (rw) begin
            bit single = (eff == 4) && m_ws;
            bit pg = (m_bl == 7) && !single;
            b_left = single ? 1 : blen(m_bl);
            b_wr = (eff == 4);
            b_ap = a[10] && !pg;
            b_bank = b;
        end else if (stp) begin
            b_left = 0; b_ap = 0;
        end else begin
            if (eff == 6 && (a[10] || b == b_bank)) b_ap = 0;
            if (b_left == 1) b_ap = 0;
            if (b_left > 0) b_left--;
        end
        if (eff == 9 && !ill) begin m_bl = a[2:0]; m_ws = a[9]; end
        if (m_sr && ck) m_sr = 0;
        else if (eff == 8 && !ill) m_sr = 1;
        m_cmd = eff;
        m_ill = ill;
        dq_hist.push_back(dq);
        void'(dq_hist.pop_front());
    endtask

    task automatic compare_regs();
        chk(cmd_o == 4'(m_cmd), "R1", "cmd_o", cmd_o, m_cmd);
        chk(illegal_o == m_ill, cur_req, "illegal_o", illegal_o, m_ill);
        for (int k = 0; k < 4; k++) begin
            chk(bank_open_o[k] == m_open[k], cur_req, "bank_open", bank_open_o[k], m_open[k]);
            chk(bank_row_o[k*13 +: 13] == 13'(m_row[k]), cur_req, "bank_row",
                bank_row_o[k*13 +: 13], m_row[k]);
        end
        chk(rd_hiz_o == dq_hist[0], "R9", "rd_hiz_o", rd_hiz_o, dq_hist[0]);
    endtask

    // One command cycle: drive at the falling edge, check the write mask,
    // update the model at the rising edge, compare at the next falling edge.
    task automatic step(input logic [3:0] p, input logic ck, input logic [12:0] a,
                        input logic [1:0] b, input logic dq);
        int  eff;
        bit  ill, expm;
        {cs_n, ras_n, cas_n, we_n} = p;
        cke = ck; addr = a; ba = b; dqm = dq;
        #1;
        eff  = m_sr ? 10 : decode(p, ck);
        ill  = m_sr ? 1'b0 : judge(eff, b);
        expm = dq && ((eff == 4 && !ill) || (b_wr && b_left >= 2));
        chk(wr_mask_o == expm, "R10", "wr_mask_o", wr_mask_o, expm);
        @(posedge clk);
        model_update(p, ck, a, b, dq);
        @(negedge clk);
        compare_regs();
    endtask

    task automatic nops(input int n);
        for (int i = 0; i < n; i++) step(P_NOP, 1'b1, 13'h0, 2'd0, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog R11: run did not complete, actual 0 expected 1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        cur_req = "R11";
        compare_regs();
        chk(wr_mask_o == 1'b0, "R11", "wr_mask_o", wr_mask_o, 0);
        rst_n = 1'b1;
        nops(2);

        // R1: every encoding, including inhibit
        cur_req = "R1";
        step(P_INH, 1'b1, 13'h0, 2'd0, 1'b0);
        step(P_BT,  1'b1, 13'h0, 2'd0, 1'b0);
        step(P_PRE, 1'b1, 13'h0, 2'd1, 1'b0);
        step(P_REF, 1'b1, 13'h0, 2'd0, 1'b0);

        // R2: open two banks with distinct rows
        cur_req = "R2";
        step(P_ACT, 1'b1, 13'h1234, 2'd0, 1'b0);
        step(P_ACT, 1'b1, 13'h0ABC, 2'd2, 1'b0);
        // R3: activate an already open bank
        cur_req = "R3";
        step(P_ACT, 1'b1, 13'h1FFF, 2'd0, 1'b0);
        // R6: read and write to idle banks
        cur_req = "R6";
        step(P_RD, 1'b1, 13'h0010, 2'd1, 1'b0);
        step(P_WR, 1'b1, 13'h0010, 2'd3, 1'b1);
        // R7: mode load and refreshes with open banks
        cur_req = "R7";
        step(P_LMR, 1'b1, 13'h0003, 2'd0, 1'b0);
        step(P_REF, 1'b1, 13'h0, 2'd0, 1'b0);
        step(P_REF, 1'b0, 13'h0, 2'd0, 1'b0);
        // R9: read with a mask pattern
        cur_req = "R9";
        step(P_RD, 1'b1, 13'h0004, 2'd0, 1'b1);
        step(P_NOP, 1'b1, 13'h0, 2'd0, 1'b0);
        step(P_NOP, 1'b1, 13'h0, 2'd0, 1'b1);
        step(P_NOP, 1'b1, 13'h0, 2'd0, 1'b1);
        nops(2);
        // R4: single then all-bank precharge
        cur_req = "R4";
        step(P_PRE, 1'b1, 13'h0000, 2'd0, 1'b0);
        step(P_ACT, 1'b1, 13'h0111, 2'd1, 1'b0);
        step(P_PRE, 1'b1, 13'h0400, 2'd3, 1'b0);

        // R5: burst length 4, read with auto-precharge
        cur_req = "R5";
        step(P_LMR, 1'b1, 13'h0002, 2'd0, 1'b0);
        step(P_ACT, 1'b1, 13'h0222, 2'd1, 1'b0);
        step(P_RD,  1'b1, 13'h0400, 2'd1, 1'b0);
        nops(5);
        // R10: write burst of 4 with mask toggling, auto-precharge
        cur_req = "R10";
        step(P_ACT, 1'b1, 13'h0333, 2'd2, 1'b0);
        step(P_WR,  1'b1, 13'h0400, 2'd2, 1'b1);
        step(P_NOP, 1'b1, 13'h0, 2'd0, 1'b0);
        step(P_NOP, 1'b1, 13'h0, 2'd0, 1'b1);
        step(P_NOP, 1'b1, 13'h0, 2'd0, 1'b1);
        step(P_NOP, 1'b1, 13'h0, 2'd0, 1'b1);
        nops(2);
        // R5: single-location writes with length 8
        cur_req = "R5";
        step(P_LMR, 1'b1, 13'h0203, 2'd0, 1'b0);
        step(P_ACT, 1'b1, 13'h0444, 2'd3, 1'b0);
        step(P_WR,  1'b1, 13'h0400, 2'd3, 1'b1);
        step(P_NOP, 1'b1, 13'h0, 2'd0, 1'b1);
        nops(2);
        // R5: full page ignores auto-precharge
        step(P_LMR, 1'b1, 13'h0007, 2'd0, 1'b0);
        step(P_ACT, 1'b1, 13'h0555, 2'd0, 1'b0);
        step(P_RD,  1'b1, 13'h0400, 2'd0, 1'b0);
        nops(20);
        // R12: stop, newer command, precharge cancel pending close
        cur_req = "R12";
        step(P_BT,  1'b1, 13'h0, 2'd0, 1'b0);
        step(P_PRE, 1'b1, 13'h0400, 2'd0, 1'b0);
        step(P_LMR, 1'b1, 13'h0002, 2'd0, 1'b0);
        step(P_ACT, 1'b1, 13'h0666, 2'd1, 1'b0);
        step(P_RD,  1'b1, 13'h0400, 2'd1, 1'b0);
        step(P_BT,  1'b1, 13'h0, 2'd0, 1'b0);
        nops(5);
        step(P_RD,  1'b1, 13'h0400, 2'd1, 1'b0);
        step(P_NOP, 1'b1, 13'h0, 2'd0, 1'b0);
        step(P_RD,  1'b1, 13'h0000, 2'd1, 1'b0);
        nops(5);
        step(P_ACT, 1'b1, 13'h0777, 2'd2, 1'b0);
        step(P_WR,  1'b1, 13'h0400, 2'd1, 1'b0);
        step(P_PRE, 1'b1, 13'h0000, 2'd2, 1'b0);
        nops(5);

        // R8: self refresh entry, ignored commands, exit
        cur_req = "R8";
        step(P_PRE, 1'b1, 13'h0400, 2'd0, 1'b0);
        step(P_REF, 1'b0, 13'h0, 2'd0, 1'b0);
        step(P_ACT, 1'b0, 13'h0888, 2'd0, 1'b0);
        step(P_LMR, 1'b0, 13'h0001, 2'd0, 1'b0);
        step(P_ACT, 1'b1, 13'h0999, 2'd1, 1'b0);
        step(P_ACT, 1'b1, 13'h0AAA, 2'd1, 1'b0);
        step(P_PRE, 1'b1, 13'h0400, 2'd0, 1'b0);

        // Mixed random phase across every rule (R1..R12)
        cur_req = "R1";
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] pats[9] = '{P_INH, P_NOP, P_ACT, P_RD, P_WR, P_BT, P_PRE, P_REF, P_LMR};
            int sel = $urandom_range(0, 8);
            logic ck = ($urandom_range(0, 7) != 0);
            step(pats[sel], ck, 13'($urandom), 2'($urandom), 1'($urandom));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule